// File: doc/BRIEF.md
# I2C bit timing engine

This block sits between an I2C master's byte sequencer and the two open-drain bus lines. It counts cycles of the internal clock to shape every bus event: SCL low and high phases, data setup ahead of the SCL rising edge, and the setup and hold spacing around START and STOP conditions. The sequencer issues one bit-level request at a time: START, STOP, write bit or read bit. The engine then drives the lines. When the request finishes it returns a one-cycle completion pulse and, for a read, the sampled SDA value.

Four cycle counts set the timing: full SCL period, SCL low length, repeated-START/STOP setup and data setup. The SCL high length is the period minus the low length. With a 50 MHz internal clock at 400 kHz, the usual settings are 125, 62, 62 and 7. The counts are captured only when a request is accepted, so they may be rewritten at any time without disturbing a request in flight. A run enable holds the engine idle with both lines released. A release input lets go of an SCL line that the engine is holding low between requests. While SCL is released, its read-back value is watched, and a target that holds SCL low stretches the high phase.

Top module: `i2c_bit_timer`

## Requirements
- R1: While run_en is 0, scl_oe and sda_oe are 0 from the next cycle on, req_ready is 0, done stays 0 and requests are ignored; the same outputs, and rd_bit, are 0 after reset.
- R2: Dropping run_en during a request abandons it: both lines are released from the next cycle, no done pulse follows, and the engine afterwards treats SCL as not held.
- R3: A write or read bit first drives SCL low (scl_oe=1) for LO cycles, LO being the low count or 1 if that is 0; the new SDA level appears exactly min(data setup, LO) cycles before SCL is released and is held until the request ends.
- R4: After the low phase SCL is released for HI cycles in which SCL reads high, HI being period minus LO when positive and 1 otherwise; cycles in which scl_in reads low do not count, which lengthens the phase (clock stretching).
- R5: A read bit captures sda_in into rd_bit in high-phase cycle floor(HI/2), counting only cycles with SCL read high from 0; rd_bit holds that value when done pulses.
- R6: A START while SCL is not held releases both lines for SU counted high cycles and then drives SDA low for SU more, SU being the setup count or 1 if that is 0; it then ends with SCL and SDA both held low.
- R7: A START while SCL is held low (repeated START) first keeps SCL low with SDA released for LO cycles, then proceeds as in R6.
- R8: A STOP drives SCL and SDA low for LO cycles, releases SCL with SDA low for SU counted cycles, then releases SDA and waits HI counted cycles as bus free time; it ends with both lines released.
- R9: req_ready is high only when idle with run_en set; a request is taken on the cycle req_valid and req_ready are both high, req_ready is low from the next cycle until completion, and done is a single-cycle pulse in the first idle cycle.
- R10: The four timing counts are captured when a request is accepted; changing cfg inputs during a request has no effect on it.
- R11: A one-cycle scl_release while idle with no request releases a held SCL from the next cycle and leaves sda_oe unchanged.
- R12: req_op encodes 0 = START, 1 = STOP, 2 = write bit, 3 = read bit; a written 1 releases SDA (sda_oe=0), a written 0 drives it low (sda_oe=1), and a read bit releases SDA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_period | input | CW | SCL period in clock cycles |
| cfg_low | input | CW | SCL low length in clock cycles |
| cfg_rs_setup | input | CW | Repeated-START/STOP setup in clock cycles |
| cfg_dat_setup | input | CW | Data setup before SCL rise in clock cycles |
| run_en | input | 1 | Normal operation enable; 0 holds the engine idle and released |
| scl_release | input | 1 | Lets go of an SCL line held low while idle |
| req_valid | input | 1 | Bit request present |
| req_op | input | 2 | Request kind (see R12) |
| req_bit | input | 1 | Bit value for a write request |
| req_ready | output | 1 | Engine idle and able to take a request |
| done | output | 1 | One-cycle completion pulse |
| rd_bit | output | 1 | SDA value sampled by the last read bit |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| scl_in | input | 1 | SCL level read back from the bus |
| sda_in | input | 1 | SDA level read back from the bus |

## Verification
The bench aims at the clamping edges: a low count of zero, a period no longer than the low count, and a data setup equal to or above the low length. A design that miscounted those would show a phase one cycle off, or change SDA while SCL is high. Clock stretching in the high phase is checked, as is the sample point of a read. For the read, the modelled target shows the wanted level only in the one cycle the engine should sample, so a sampler that ignored a stretched cycle or sampled off-centre would return the inverted bit. Rewriting the timing counts during a request, aborting through run_en, and releasing a held SCL are each checked as well, because a design that read the live inputs, emitted a stray done or forgot the held state would break the line traces that follow.

// File: rtl/i2c_bt_pkg.sv
package i2c_bt_pkg;

   typedef enum logic [1:0] {
      OP_START = 2'd0,
      OP_STOP  = 2'd1,
      OP_WRITE = 2'd2,
      OP_READ  = 2'd3
   } bt_op_e;

   typedef enum logic [3:0] {
      PH_IDLE    = 4'd0,
      PH_BIT_LO  = 4'd1,
      PH_BIT_HI  = 4'd2,
      PH_ST_PREP = 4'd3,
      PH_ST_SU   = 4'd4,
      PH_ST_HOLD = 4'd5,
      PH_SP_PREP = 4'd6,
      PH_SP_SU   = 4'd7,
      PH_SP_BUF  = 4'd8
   } bt_phase_e;

endpackage

// File: rtl/i2c_bt_sync.sv
module i2c_bt_sync #(
   parameter int STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 0) begin : g_thru
         logic sync_unused;
         assign sync_unused = clk ^ rst_n;
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] sr;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr <= '1;
            else        sr <= (sr << 1) | STAGES'(d);
         end
         assign q = sr[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/i2c_bt_cfg.sv
module i2c_bt_cfg #(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] period_i,
   input  logic [CW-1:0] low_i,
   input  logic [CW-1:0] rs_i,
   input  logic [CW-1:0] dat_i,
   output logic [CW-1:0] lo_o,
   output logic [CW-1:0] hi_o,
   output logic [CW-1:0] su_o,
   output logic [CW-1:0] dpos_o,
   output logic [CW-1:0] half_o
);
   localparam logic [CW-1:0] ONE = CW'(1);

   logic [CW-1:0] lo_c, hi_c, su_c, dpos_c;

   always_comb begin
      lo_c   = (low_i == '0) ? ONE : low_i;
      hi_c   = (period_i > lo_c) ? (period_i - lo_c) : ONE;
      su_c   = (rs_i == '0) ? ONE : rs_i;
      dpos_c = (dat_i < lo_c) ? (lo_c - dat_i) : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_o   <= ONE;
         hi_o   <= ONE;
         su_o   <= ONE;
         dpos_o <= '0;
         half_o <= '0;
      end else if (load) begin
         lo_o   <= lo_c;
         hi_o   <= hi_c;
         su_o   <= su_c;
         dpos_o <= dpos_c;
         half_o <= hi_c >> 1;
      end
   end
endmodule

// File: rtl/i2c_bt_phase_ctr.sv
module i2c_bt_phase_ctr #(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          adv,
   input  logic [CW-1:0] tgt,
   output logic [CW-1:0] cnt,
   output logic          last
);
   assign last = adv && (cnt == (tgt - CW'(1)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (clr) cnt <= '0;
      else if (adv) cnt <= cnt + CW'(1);
   end
endmodule

// File: rtl/i2c_bit_timer.sv
module i2c_bit_timer
   import i2c_bt_pkg::*;
#(
   parameter int CW          = 16,
   parameter int SYNC_STAGES = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] cfg_period,
   input  logic [CW-1:0] cfg_low,
   input  logic [CW-1:0] cfg_rs_setup,
   input  logic [CW-1:0] cfg_dat_setup,
   input  logic          run_en,
   input  logic          scl_release,
   input  logic          req_valid,
   input  logic [1:0]    req_op,
   input  logic          req_bit,
   output logic          req_ready,
   output logic          done,
   output logic          rd_bit,
   output logic          scl_oe,
   output logic          sda_oe,
   input  logic          scl_in,
   input  logic          sda_in
);
   localparam int NLINES = 2;

   generate
      if (CW < 4 || CW > 32) begin : g_bad_cw
         $error("i2c_bit_timer: CW must lie in 4..32");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 3) begin : g_bad_sync
         $error("i2c_bit_timer: SYNC_STAGES must lie in 0..3");
      end
   endgenerate

   // line read-back, one conditioning stage per bus line
   logic [NLINES-1:0] line_raw, line_s;
   logic              scl_s, sda_s;
   assign line_raw = {sda_in, scl_in};

   generate
      for (genvar gi = 0; gi < NLINES; gi++) begin : g_line
         i2c_bt_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (line_raw[gi]),
            .q     (line_s[gi])
         );
      end
   endgenerate

   assign scl_s = line_s[0];
   assign sda_s = line_s[1];

   // captured timing
   logic [CW-1:0] lo_len, hi_len, su_len, dpos, half_hi;
   logic          accept;

   i2c_bt_cfg #(.CW(CW)) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .period_i (cfg_period),
      .low_i    (cfg_low),
      .rs_i     (cfg_rs_setup),
      .dat_i    (cfg_dat_setup),
      .lo_o     (lo_len),
      .hi_o     (hi_len),
      .su_o     (su_len),
      .dpos_o   (dpos),
      .half_o   (half_hi)
   );

   // phase sequencing
   bt_phase_e     ph, ph_start;
   logic [CW-1:0] cnt, tgt;
   logic          adv, last, clr;
   logic          scl_hold, sda_drv, new_sda, done_q, rd_q;
   logic          high_phase;

   always_comb begin
      req_ready = run_en && (ph == PH_IDLE);
      accept    = req_valid && req_ready;
   end

   always_comb begin
      unique case (ph)
         PH_BIT_LO, PH_ST_PREP, PH_SP_PREP: tgt = lo_len;
         PH_BIT_HI, PH_SP_BUF:              tgt = hi_len;
         PH_ST_SU, PH_ST_HOLD, PH_SP_SU:    tgt = su_len;
         default:                           tgt = CW'(1);
      endcase
   end

   always_comb begin
      unique case (ph)
         PH_BIT_HI, PH_ST_SU, PH_ST_HOLD, PH_SP_SU, PH_SP_BUF: high_phase = 1'b1;
         default:                                             high_phase = 1'b0;
      endcase
      if (ph == PH_IDLE) adv = 1'b0;
      else if (high_phase) adv = scl_s;
      else adv = 1'b1;
      clr = !run_en || accept || last;
   end

   always_comb begin
      unique case (bt_op_e'(req_op))
         OP_START: ph_start = scl_hold ? PH_ST_PREP : PH_ST_SU;
         OP_STOP:  ph_start = PH_SP_PREP;
         default:  ph_start = PH_BIT_LO;
      endcase
   end

   i2c_bt_phase_ctr #(.CW(CW)) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .adv   (adv),
      .tgt   (tgt),
      .cnt   (cnt),
      .last  (last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph       <= PH_IDLE;
         scl_hold <= 1'b0;
         sda_drv  <= 1'b0;
         new_sda  <= 1'b0;
         done_q   <= 1'b0;
      end else if (!run_en) begin
         ph       <= PH_IDLE;
         scl_hold <= 1'b0;
         sda_drv  <= 1'b0;
         done_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (ph == PH_IDLE) begin
            if (accept) begin
               ph      <= ph_start;
               new_sda <= (bt_op_e'(req_op) == OP_WRITE) ? !req_bit : 1'b0;
            end else if (scl_release) begin
               scl_hold <= 1'b0;
            end
         end else if (last) begin
            unique case (ph)
               PH_BIT_LO: begin
                  ph      <= PH_BIT_HI;
                  sda_drv <= new_sda;
               end
               PH_BIT_HI: begin
                  ph       <= PH_IDLE;
                  scl_hold <= 1'b1;
                  done_q   <= 1'b1;
               end
               PH_ST_PREP: ph <= PH_ST_SU;
               PH_ST_SU:   ph <= PH_ST_HOLD;
               PH_ST_HOLD: begin
                  ph       <= PH_IDLE;
                  scl_hold <= 1'b1;
                  sda_drv  <= 1'b1;
                  done_q   <= 1'b1;
               end
               PH_SP_PREP: ph <= PH_SP_SU;
               PH_SP_SU:   ph <= PH_SP_BUF;
               PH_SP_BUF: begin
                  ph       <= PH_IDLE;
                  scl_hold <= 1'b0;
                  sda_drv  <= 1'b0;
                  done_q   <= 1'b1;
               end
               default: ph <= PH_IDLE;
            endcase
         end
      end
   end

   // read sampling at the centre of the counted high phase
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_q <= 1'b0;
      else if (run_en && (ph == PH_BIT_HI) && adv && (cnt == half_hi)) rd_q <= sda_s;
   end

   always_comb begin
      unique case (ph)
         PH_IDLE:    begin scl_oe = scl_hold; sda_oe = sda_drv; end
         PH_BIT_LO:  begin scl_oe = 1'b1; sda_oe = (cnt >= dpos) ? new_sda : sda_drv; end
         PH_BIT_HI:  begin scl_oe = 1'b0; sda_oe = sda_drv; end
         PH_ST_PREP: begin scl_oe = 1'b1; sda_oe = 1'b0; end
         PH_ST_SU:   begin scl_oe = 1'b0; sda_oe = 1'b0; end
         PH_ST_HOLD: begin scl_oe = 1'b0; sda_oe = 1'b1; end
         PH_SP_PREP: begin scl_oe = 1'b1; sda_oe = 1'b1; end
         PH_SP_SU:   begin scl_oe = 1'b0; sda_oe = 1'b1; end
         PH_SP_BUF:  begin scl_oe = 1'b0; sda_oe = 1'b0; end
         default:    begin scl_oe = 1'b0; sda_oe = 1'b0; end
      endcase
   end

   assign done   = done_q;
   assign rd_bit = rd_q;

endmodule

// File: rtl/i2c_bit_timer_chk.sv
module i2c_bit_timer_chk #(
   parameter int CW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          run_en,
   input logic          req_valid,
   input logic          req_ready,
   input logic          done,
   input logic          rd_bit,
   input logic          scl_oe,
   input logic          sda_oe,
   input logic          scl_in,
   input logic [CW-1:0] lat_hi
);
   assert_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en |=> (!scl_oe && !sda_oe && !done));

   assert_single_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_busy_after_take_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (!req_ready && !done));

   assert_timing_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !req_ready |=> $stable(lat_hi));

   assert_sample_when_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rd_bit) |-> $past(scl_in));
endmodule

bind i2c_bit_timer i2c_bit_timer_chk #(.CW(CW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .run_en    (run_en),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .done      (done),
   .rd_bit    (rd_bit),
   .scl_oe    (scl_oe),
   .sda_oe    (sda_oe),
   .scl_in    (scl_in),
   .lat_hi    (hi_len)
);

// File: tb/i2c_bit_timer_tb.sv
`timescale 1ns/1ps
module i2c_bit_timer_tb;
   localparam int CW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [CW-1:0] cfg_period = '0, cfg_low = '0, cfg_rs_setup = '0, cfg_dat_setup = '0;
   logic          run_en = 1'b0, scl_release = 1'b0;
   logic          req_valid = 1'b0, req_bit = 1'b0;
   logic [1:0]    req_op = 2'd0;
   logic          req_ready, done, rd_bit, scl_oe, sda_oe, scl_in, sda_in;
   logic          hold_low = 1'b0, tgt_low = 1'b0;

   assign scl_in = ~scl_oe & ~hold_low;
   assign sda_in = ~sda_oe & ~tgt_low;

   i2c_bit_timer #(.CW(CW)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .cfg_period(cfg_period), .cfg_low(cfg_low),
      .cfg_rs_setup(cfg_rs_setup), .cfg_dat_setup(cfg_dat_setup),
      .run_en(run_en), .scl_release(scl_release),
      .req_valid(req_valid), .req_op(req_op), .req_bit(req_bit), .req_ready(req_ready),
      .done(done), .rd_bit(rd_bit), .scl_oe(scl_oe), .sda_oe(sda_oe),
      .scl_in(scl_in), .sda_in(sda_in)
   );

   always #10 clk = ~clk;

   int n_chk = 0, n_err = 0;
   bit finished = 1'b0;
   int cur_p, cur_l, cur_s, cur_d;
   bit m_hold = 1'b0, m_sda = 1'b0;
   int g_scl[16], g_sda[16], g_len[16], g_n;
   int e_scl[16], e_sda[16], e_len[16], e_n;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int f_lo(input int l);           return (l == 0) ? 1 : l; endfunction
   function automatic int f_hi(input int p, input int l); return (p > f_lo(l)) ? p - f_lo(l) : 1; endfunction
   function automatic int f_su(input int s);           return (s == 0) ? 1 : s; endfunction
   function automatic int f_dp(input int d, input int l); return (d < f_lo(l)) ? f_lo(l) - d : 0; endfunction

   task automatic apply_cfg(input int p, input int l, input int s, input int d);
      cur_p = p; cur_l = l; cur_s = s; cur_d = d;
      cfg_period = CW'(p); cfg_low = CW'(l); cfg_rs_setup = CW'(s); cfg_dat_setup = CW'(d);
   endtask

   task automatic add_exp(input int s, input int d, input int len);
      if (len <= 0) return;
      if (e_n > 0 && e_scl[e_n-1] == s && e_sda[e_n-1] == d) e_len[e_n-1] += len;
      else if (e_n < 16) begin
         e_scl[e_n] = s; e_sda[e_n] = d; e_len[e_n] = len; e_n++;
      end
   endtask

   // op: 0 START, 1 STOP, 2 write, 3 read (R12 encoding)
   task automatic run_op(input int op, input bit b, input int stretch, input bit rdv, input bit scramble);
      int lo, hi, su, dp, half, hc, srem, nn, bad;
      bit nw, got_done;
      string tag;
      lo = f_lo(cur_l); hi = f_hi(cur_p, cur_l); su = f_su(cur_s); dp = f_dp(cur_d, cur_l);
      half = hi / 2;
      nw = (op == 2) ? ~b : 1'b0;
      e_n = 0;
      case (op)
         0: begin
            tag = m_hold ? "R7 repeated START" : "R6 START";
            if (m_hold) add_exp(1, 0, lo);
            add_exp(0, 0, su); add_exp(0, 1, su);
         end
         1: begin
            tag = "R8 STOP";
            add_exp(1, 1, lo); add_exp(0, 1, su); add_exp(0, 0, hi);
         end
         default: begin
            tag = (op == 2) ? "R3 R4 R12 write" : "R3 R4 read";
            if (dp > 0) add_exp(1, int'(m_sda), dp);
            add_exp(1, int'(nw), lo - dp);
            add_exp(0, int'(nw), hi + stretch);
         end
      endcase
      if (scramble) tag = {tag, " R10"};
      nn = 0;
      while (!req_ready && nn < 1000) begin @(negedge clk); nn++; end
      req_valid = 1'b1; req_op = 2'(op); req_bit = b;
      @(negedge clk);
      req_valid = 1'b0;
      chk(req_ready == 1'b0, "R9 busy after accept", int'(req_ready), 0);
      if (scramble) begin
         cfg_period = CW'($urandom % 200); cfg_low = CW'($urandom % 200);
         cfg_rs_setup = CW'($urandom % 50); cfg_dat_setup = CW'($urandom % 50);
      end
      g_n = 0; hc = 0; srem = stretch; got_done = 1'b0;
      for (int k = 0; k < 5000; k++) begin
         if (done) begin got_done = 1'b1; break; end
         if (g_n > 0 && g_scl[g_n-1] == int'(scl_oe) && g_sda[g_n-1] == int'(sda_oe)) g_len[g_n-1]++;
         else if (g_n < 16) begin
            g_scl[g_n] = int'(scl_oe); g_sda[g_n] = int'(sda_oe); g_len[g_n] = 1; g_n++;
         end
         if (op >= 2 && !scl_oe && srem > 0) begin hold_low = 1'b1; srem--; end
         else hold_low = 1'b0;
         if (op == 3 && !scl_oe) tgt_low = (!hold_low && hc == half) ? ~rdv : rdv;
         else tgt_low = 1'b0;
         if (!scl_oe && !hold_low) hc++;
         @(negedge clk);
      end
      hold_low = 1'b0; tgt_low = 1'b0;
      chk(got_done, {tag, " done seen"}, int'(got_done), 1);
      bad = -1;
      if (g_n != e_n) bad = 99;
      else for (int i = 0; i < e_n; i++)
         if (bad < 0 && (g_scl[i] != e_scl[i] || g_sda[i] != e_sda[i] || g_len[i] != e_len[i])) bad = i;
      if (bad == 99) chk(1'b0, {tag, " segment count"}, g_n, e_n);
      else if (bad >= 0)
         chk(1'b0, {tag, " segment scl*1000+sda*100+len"},
             g_scl[bad]*1000 + g_sda[bad]*100 + g_len[bad],
             e_scl[bad]*1000 + e_sda[bad]*100 + e_len[bad]);
      else chk(1'b1, tag, 0, 0);
      case (op)
         0: begin m_hold = 1'b1; m_sda = 1'b1; end
         1: begin m_hold = 1'b0; m_sda = 1'b0; end
         default: begin m_hold = 1'b1; m_sda = nw; end
      endcase
      chk(scl_oe == m_hold, {tag, " scl after"}, int'(scl_oe), int'(m_hold));
      chk(sda_oe == m_sda, {tag, " sda after"}, int'(sda_oe), int'(m_sda));
      if (op == 3) chk(rd_bit == rdv, "R5 read sample", int'(rd_bit), int'(rdv));
      @(negedge clk);
      chk(done == 1'b0, "R9 done single pulse", int'(done), 0);
      if (scramble) apply_cfg(cur_p, cur_l, cur_s, cur_d);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         n_err++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      int p, l, nb, op;
      void'($urandom(32'd4242));
      apply_cfg(125, 62, 62, 7);
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset / disabled state
      chk(scl_oe == 0 && sda_oe == 0, "R1 reset lines", int'({scl_oe, sda_oe}), 0);
      chk(req_ready == 0 && done == 0 && rd_bit == 0, "R1 reset outputs",
          int'({req_ready, done, rd_bit}), 0);
      req_valid = 1'b1; req_op = 2'd0;
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         chk(!done && !req_ready && !scl_oe && !sda_oe, "R1 request ignored while disabled",
             int'({done, req_ready, scl_oe, sda_oe}), 0);
      end
      req_valid = 1'b0;
      run_en = 1'b1;
      @(negedge clk);

      // directed at nominal 400 kHz counts
      run_op(0, 0, 0, 0, 0);
      run_op(2, 1, 0, 0, 0);
      run_op(2, 0, 0, 0, 0);
      run_op(3, 0, 0, 1, 0);
      run_op(3, 0, 3, 0, 0);
      run_op(0, 0, 0, 0, 0);
      run_op(2, 0, 2, 0, 1);
      run_op(1, 0, 0, 0, 0);

      // clamp corners: low 0, period <= low, data setup >= low, setup 0
      apply_cfg(5, 0, 0, 9);
      run_op(0, 0, 0, 0, 0); run_op(2, 0, 0, 0, 0); run_op(3, 0, 1, 1, 0); run_op(1, 0, 0, 0, 0);
      apply_cfg(6, 6, 2, 6);
      run_op(0, 0, 0, 0, 0); run_op(3, 0, 0, 0, 0); run_op(2, 1, 0, 0, 0); run_op(1, 0, 0, 0, 0);

      // R11: release a held SCL while idle
      apply_cfg(20, 10, 5, 3);
      run_op(0, 0, 0, 0, 0);
      run_op(2, 0, 0, 0, 0);
      scl_release = 1'b1;
      @(negedge clk);
      scl_release = 1'b0;
      chk(scl_oe == 0, "R11 scl released", int'(scl_oe), 0);
      chk(sda_oe == 1, "R11 sda unchanged", int'(sda_oe), 1);
      m_hold = 1'b0;
      run_op(1, 0, 0, 0, 0);

      // R2: abort through run_en
      run_op(0, 0, 0, 0, 0);
      req_valid = 1'b1; req_op = 2'd2; req_bit = 1'b0;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (3) @(negedge clk);
      run_en = 1'b0;
      @(negedge clk);
      chk(!scl_oe && !sda_oe, "R2 lines released on abort", int'({scl_oe, sda_oe}), 0);
      chk(!done, "R2 no done on abort", int'(done), 0);
      @(negedge clk);
      chk(!req_ready && !done, "R2 ready low while disabled", int'({req_ready, done}), 0);
      run_en = 1'b1;
      @(negedge clk);
      chk(!scl_oe && !sda_oe && req_ready, "R2 idle released after abort",
          int'({scl_oe, sda_oe, req_ready}), 1);
      m_hold = 1'b0; m_sda = 1'b0;

      // constrained random transactions
      for (int it = 0; it < 30; it++) begin
         p = 4 + int'($urandom % 40);
         l = int'($urandom % (p + 1));
         apply_cfg(p, l, int'($urandom % 12), int'($urandom % (p + 2)));
         run_op(0, 0, 0, 0, ($urandom % 3) == 0);
         nb = 1 + int'($urandom % 4);
         for (int j = 0; j < nb; j++) begin
            op = 2 + int'($urandom % 2);
            run_op(op, 1'($urandom), int'($urandom % 4), 1'($urandom), ($urandom % 3) == 0);
         end
         if (($urandom % 3) == 0) begin
            run_op(0, 0, 0, 0, 0);
            run_op(3, 0, int'($urandom % 3), 1'($urandom), 0);
         end
         run_op(1, 0, 0, 0, ($urandom % 3) == 0);
      end

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule